// File: doc/BRIEF.md
# Framing Header Receive Filter

This block sits on the receive side of a packet link and looks at the first 64-bit word of every packet, which carries the framing header. From that word it decides whether the packet is delivered or thrown away. Accepted packets are forwarded word for word and tagged with an output queue index. Rejected packets are consumed from the link and suppressed completely. The queue index comes from a small table of known protocol identifiers that software loads through a simple write port.

Packets that carry the LAN-encapsulation identifier (value 4) are checked more strictly. The header must announce control data, declare a control area of exactly three 64-bit words, and carry no more than 65536 bytes of payload. For each accepted packet, the decoded header fields are held on dedicated outputs while its words stream out. Each class of rejection has its own saturating counter.

Top module: `fp_hdr_filter`

## Requirements
- R1: While reset is active and immediately after it, all stream outputs, acc_o, drop_o, the held header fields and all four counters are zero, and every table entry is disabled.
- R2: A write with tbl_we_i high loads entry tbl_idx_i with identifier tbl_id_i, queue tbl_q_i and enable tbl_en_i, and the entry is used from the next header onward. When several enabled entries hold the same identifier, the entry with the lowest index supplies the queue.
- R3: Every word of an accepted packet appears on out_data_o exactly one clock after it is presented. out_sop_o and out_eop_o copy the input markers, and out_qsel_o equals the queue of the matching table entry for the whole packet.
- R4: A header whose identifier (bits 63:56) matches no enabled table entry drops the whole packet through its end-of-packet word. drop_o pulses once, one clock after the header, and cnt_unknown_o increments by one.
- R5: An identifier-4 packet whose control-present flag (bit 55) is 0 is dropped, and cnt_lan_d1p_o increments by one.
- R6: An identifier-4 packet whose control area size (bits 42:35, counted in 64-bit words) is not 3 is dropped, and cnt_lan_d1sz_o increments by one.
- R7: An identifier-4 packet whose payload byte count (bits 31:0) exceeds 65536 is dropped, and cnt_lan_len_o increments by one. A count of exactly 65536 is accepted.
- R8: Only one counter increments per dropped packet, chosen in this order: unknown identifier first, then control-present, then area size, then byte count.
- R9: For an accepted header, the following fields appear in the same clock as out_sop_o and stay unchanged until the next accepted header: identifier, control-present (bit 55), burst-boundary (bit 54), area size, payload offset (bits 34:32) and byte count. Dropped packets leave these fields untouched.
- R10: Identifiers other than 4 that hit the table are accepted whatever the values of their other header fields.
- R11: A clock with in_valid_i low produces no output word. A valid word without start-of-packet while no packet is open is suppressed and counts nothing. A word marked with both start and end is a complete one-word packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 2 | Table entry index |
| tbl_en_i | input | 1 | Entry enable value |
| tbl_id_i | input | 8 | Protocol identifier for entry |
| tbl_q_i | input | 2 | Output queue for entry |
| in_valid_i | input | 1 | Input word valid |
| in_sop_i | input | 1 | Input start of packet |
| in_eop_i | input | 1 | Input end of packet |
| in_data_i | input | 64 | Input word |
| out_valid_o | output | 1 | Output word valid |
| out_sop_o | output | 1 | Output start of packet |
| out_eop_o | output | 1 | Output end of packet |
| out_data_o | output | 64 | Output word |
| out_qsel_o | output | 2 | Queue index of current packet |
| acc_o | output | 1 | Header accepted pulse |
| drop_o | output | 1 | Header dropped pulse |
| hdr_ulp_o | output | 8 | Held protocol identifier |
| hdr_d1p_o | output | 1 | Held control-present flag |
| hdr_bb_o | output | 1 | Held burst-boundary flag |
| hdr_d1sz_o | output | 8 | Held control area size |
| hdr_d2off_o | output | 3 | Held payload offset |
| hdr_d2cnt_o | output | 32 | Held payload byte count |
| cnt_unknown_o | output | 16 | Unknown identifier drops |
| cnt_lan_d1p_o | output | 16 | Identifier-4 missing-control drops |
| cnt_lan_d1sz_o | output | 16 | Identifier-4 area-size drops |
| cnt_lan_len_o | output | 16 | Identifier-4 oversize drops |

## Verification
The bench targets the 65536/65537 byte-count edge. A design off by one there would drop the legal maximum or pass an oversize packet. It also sends headers that break several identifier-4 rules at once: a design that checks the reasons in the wrong order, or counts every reason, would move the wrong counter or more than one. Duplicate table identifiers, a later disable of an entry, stray words outside a packet, and single-word packets are each exercised. These would show up as a wrong queue, leaked words or corrupted held fields. After every dropped packet, the bench checks that the held header fields still match the last accepted packet.

// File: rtl/fp_filt_pkg.sv
package fp_filt_pkg;

  typedef struct packed {
    logic [7:0]  ulp;
    logic        d1p;
    logic        bb;
    logic [7:0]  d1sz;
    logic [2:0]  d2off;
    logic [31:0] d2cnt;
  } hdr_t;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_UNKNOWN = 3'd1,
    RSN_D1P     = 3'd2,
    RSN_D1SZ    = 3'd3,
    RSN_LEN     = 3'd4
  } rsn_e;

  localparam int unsigned N_RSN = 4;

  function automatic hdr_t unpack_hdr(input logic [63:0] w);
    hdr_t h;
    h.ulp   = w[63:56];
    h.d1p   = w[55];
    h.bb    = w[54];
    h.d1sz  = w[42:35];
    h.d2off = w[34:32];
    h.d2cnt = w[31:0];
    return h;
  endfunction

endpackage

// File: rtl/ulp_table.sv
module ulp_table #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned ID_W  = 8,
  parameter int unsigned Q_W   = 2,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [Q_W-1:0]   q_i,
  input  logic [ID_W-1:0]  look_id_i,
  output logic             hit_o,
  output logic [Q_W-1:0]   hit_q_o
);

  logic [N_ENT-1:0]           ent_en_q;
  logic [N_ENT-1:0][ID_W-1:0] ent_id_q;
  logic [N_ENT-1:0][Q_W-1:0]  ent_q_q;
  logic [N_ENT-1:0]           match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_en_q[g] <= 1'b0;
        ent_id_q[g] <= '0;
        ent_q_q[g]  <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        ent_en_q[g] <= en_i;
        ent_id_q[g] <= id_i;
        ent_q_q[g]  <= q_i;
      end
    end
    assign match[g] = ent_en_q[g] && (ent_id_q[g] == look_id_i);
  end

  // lowest matching index wins
  always_comb begin
    hit_o   = 1'b0;
    hit_q_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o   = 1'b1;
        hit_q_o = ent_q_q[i];
      end
    end
  end

  AST_HIT_HAS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match != '0)); // R2

endmodule

// File: rtl/hdr_check.sv
module hdr_check
  import fp_filt_pkg::*;
#(
  parameter logic [7:0]  LAN_ULP       = 8'd4,
  parameter logic [7:0]  LAN_D1_WORDS  = 8'd3,
  parameter logic [31:0] LAN_MAX_BYTES = 32'd65536
) (
  input  logic        hit_i,
  input  logic [7:0]  ulp_i,
  input  logic        d1p_i,
  input  logic [7:0]  d1sz_i,
  input  logic [31:0] d2cnt_i,
  output rsn_e        rsn_o
);

  logic is_lan;
  assign is_lan = (ulp_i == LAN_ULP);

  // fixed priority: unknown, then control flag, size, length
  always_comb begin
    if (!hit_i)                            rsn_o = RSN_UNKNOWN;
    else if (is_lan && !d1p_i)             rsn_o = RSN_D1P;
    else if (is_lan && (d1sz_i != LAN_D1_WORDS)) rsn_o = RSN_D1SZ;
    else if (is_lan && (d2cnt_i > LAN_MAX_BYTES)) rsn_o = RSN_LEN;
    else                                   rsn_o = RSN_NONE;
  end

endmodule

// File: rtl/drop_counters.sv
module drop_counters
  import fp_filt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         inc_i,
  input  rsn_e                         rsn_i,
  output logic [N_RSN-1:0][CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < N_RSN; g++) begin : g_cnt
    logic bump;
    assign bump = inc_i && (rsn_i == rsn_e'(g + 1)) && (cnt_o[g] != CNT_MAX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_o[g] <= '0;
      else if (bump) cnt_o[g] <= cnt_o[g] + 1'b1;
    end

    AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o[g] != $past(cnt_o[g])) |-> (cnt_o[g] == CNT_W'($past(cnt_o[g]) + 1'b1))); // R8
  end

  AST_ONE_REASON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cnt_o[0] != $past(cnt_o[0]), cnt_o[1] != $past(cnt_o[1]),
                cnt_o[2] != $past(cnt_o[2]), cnt_o[3] != $past(cnt_o[3])}) <= 1); // R8

endmodule

// File: rtl/fp_hdr_filter.sv
module fp_hdr_filter
  import fp_filt_pkg::*;
#(
  parameter int unsigned   N_ENT         = 4,
  parameter int unsigned   Q_W           = 2,
  parameter int unsigned   CNT_W         = 16,
  parameter logic [7:0]    LAN_ULP       = 8'd4,
  parameter logic [7:0]    LAN_D1_WORDS  = 8'd3,
  parameter logic [31:0]   LAN_MAX_BYTES = 32'd65536,
  localparam int unsigned  IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic             tbl_en_i,
  input  logic [7:0]       tbl_id_i,
  input  logic [Q_W-1:0]   tbl_q_i,
  input  logic             in_valid_i,
  input  logic             in_sop_i,
  input  logic             in_eop_i,
  input  logic [63:0]      in_data_i,
  output logic             out_valid_o,
  output logic             out_sop_o,
  output logic             out_eop_o,
  output logic [63:0]      out_data_o,
  output logic [Q_W-1:0]   out_qsel_o,
  output logic             acc_o,
  output logic             drop_o,
  output logic [7:0]       hdr_ulp_o,
  output logic             hdr_d1p_o,
  output logic             hdr_bb_o,
  output logic [7:0]       hdr_d1sz_o,
  output logic [2:0]       hdr_d2off_o,
  output logic [31:0]      hdr_d2cnt_o,
  output logic [CNT_W-1:0] cnt_unknown_o,
  output logic [CNT_W-1:0] cnt_lan_d1p_o,
  output logic [CNT_W-1:0] cnt_lan_d1sz_o,
  output logic [CNT_W-1:0] cnt_lan_len_o
);

  hdr_t                        hdr_in;
  hdr_t                        hdr_q;
  logic                        hit;
  logic [Q_W-1:0]              hit_q;
  rsn_e                        rsn;
  logic                        hdr_ok, hdr_bad, fwd;
  logic                        pkt_open_q, pkt_keep_q;
  logic [Q_W-1:0]              qsel_q;
  logic [N_RSN-1:0][CNT_W-1:0] cnt;

  assign hdr_in = unpack_hdr(in_data_i);

  ulp_table #(.N_ENT(N_ENT), .ID_W(8), .Q_W(Q_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .idx_i     (tbl_idx_i),
    .en_i      (tbl_en_i),
    .id_i      (tbl_id_i),
    .q_i       (tbl_q_i),
    .look_id_i (hdr_in.ulp),
    .hit_o     (hit),
    .hit_q_o   (hit_q)
  );

  hdr_check #(
    .LAN_ULP(LAN_ULP), .LAN_D1_WORDS(LAN_D1_WORDS), .LAN_MAX_BYTES(LAN_MAX_BYTES)
  ) u_chk (
    .hit_i   (hit),
    .ulp_i   (hdr_in.ulp),
    .d1p_i   (hdr_in.d1p),
    .d1sz_i  (hdr_in.d1sz),
    .d2cnt_i (hdr_in.d2cnt),
    .rsn_o   (rsn)
  );

  assign hdr_ok  = in_valid_i && in_sop_i && (rsn == RSN_NONE);
  assign hdr_bad = in_valid_i && in_sop_i && (rsn != RSN_NONE);
  assign fwd     = in_sop_i ? hdr_ok : (in_valid_i && pkt_open_q && pkt_keep_q);

  drop_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hdr_bad),
    .rsn_i  (rsn),
    .cnt_o  (cnt)
  );

  assign cnt_unknown_o  = cnt[0];
  assign cnt_lan_d1p_o  = cnt[1];
  assign cnt_lan_d1sz_o = cnt[2];
  assign cnt_lan_len_o  = cnt[3];

  // packet tracking and header latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_open_q <= 1'b0;
      pkt_keep_q <= 1'b0;
      qsel_q     <= '0;
      hdr_q      <= '0;
    end else if (in_valid_i) begin
      if (in_sop_i) begin
        pkt_open_q <= !in_eop_i;
        pkt_keep_q <= hdr_ok;
        if (hdr_ok) begin
          qsel_q <= hit_q;
          hdr_q  <= hdr_in;
        end
      end else if (in_eop_i) begin
        pkt_open_q <= 1'b0;
      end
    end
  end

  // output stage, one cycle latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_data_o  <= '0;
      acc_o       <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      out_valid_o <= fwd;
      out_sop_o   <= hdr_ok;
      out_eop_o   <= fwd && in_eop_i;
      acc_o       <= hdr_ok;
      drop_o      <= hdr_bad;
      if (fwd) out_data_o <= in_data_i;
    end
  end

  assign out_qsel_o  = qsel_q;
  assign hdr_ulp_o   = hdr_q.ulp;
  assign hdr_d1p_o   = hdr_q.d1p;
  assign hdr_bb_o    = hdr_q.bb;
  assign hdr_d1sz_o  = hdr_q.d1sz;
  assign hdr_d2off_o = hdr_q.d2off;
  assign hdr_d2cnt_o = hdr_q.d2cnt;

  AST_ACC_DROP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_o && drop_o)); // R4
  AST_DROP_NO_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !out_valid_o); // R4
  AST_SOP_IS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> (acc_o && out_valid_o)); // R3
  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_o |-> $stable({hdr_ulp_o, hdr_d1p_o, hdr_bb_o, hdr_d1sz_o, hdr_d2off_o, hdr_d2cnt_o})); // R9
  AST_QSEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_o |-> $stable(out_qsel_o)); // R3
  AST_LAN_RULES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && hdr_ulp_o == LAN_ULP) |->
      (hdr_d1p_o && hdr_d1sz_o == LAN_D1_WORDS && hdr_d2cnt_o <= LAN_MAX_BYTES)); // R7
  AST_DROP_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> ({cnt_unknown_o, cnt_lan_d1p_o, cnt_lan_d1sz_o, cnt_lan_len_o} !=
                $past({cnt_unknown_o, cnt_lan_d1p_o, cnt_lan_d1sz_o, cnt_lan_len_o}))); // R8

endmodule

// File: tb/fp_hdr_filter_tb_top.sv
module fp_hdr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0, tbl_en = 1'b0;
  logic [1:0]  tbl_idx = '0, tbl_q = '0;
  logic [7:0]  tbl_id = '0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid, out_sop, out_eop, acc, drop, h_d1p, h_bb;
  logic [63:0] out_data;
  logic [1:0]  out_qsel;
  logic [7:0]  h_ulp, h_d1sz;
  logic [2:0]  h_d2off;
  logic [31:0] h_d2cnt;
  logic [15:0] c_unk, c_d1p, c_d1sz, c_len;

  int n_chk = 0, n_fail = 0;
  int exp_cnt [4] = '{0, 0, 0, 0};
  logic [63:0] last_hdr = '0;

  always #4 clk = ~clk;

  fp_hdr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_en_i(tbl_en), .tbl_id_i(tbl_id), .tbl_q_i(tbl_q),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop), .out_data_o(out_data),
    .out_qsel_o(out_qsel), .acc_o(acc), .drop_o(drop),
    .hdr_ulp_o(h_ulp), .hdr_d1p_o(h_d1p), .hdr_bb_o(h_bb), .hdr_d1sz_o(h_d1sz),
    .hdr_d2off_o(h_d2off), .hdr_d2cnt_o(h_d2cnt),
    .cnt_unknown_o(c_unk), .cnt_lan_d1p_o(c_d1p), .cnt_lan_d1sz_o(c_d1sz), .cnt_lan_len_o(c_len)
  );

  typedef struct packed {
    logic [7:0]  id;
    logic        d1p;
    logic        bb;
    logic [7:0]  d1sz;
    logic [2:0]  off;
    logic [31:0] cnt;
    logic        acc;
    logic [1:0]  q;
    logic [2:0]  rsn; // 0 none, 1 unknown, 2 ctrl flag, 3 size, 4 length
  } vec_t;

  localparam int N_VEC = 10;
  localparam vec_t VECS [N_VEC] = '{
    '{8'h04, 1'b1, 1'b0, 8'd3, 3'd0, 32'd1000,   1'b1, 2'd1, 3'd0},
    '{8'h04, 1'b0, 1'b0, 8'd3, 3'd0, 32'd1000,   1'b0, 2'd0, 3'd2},
    '{8'h04, 1'b1, 1'b0, 8'd2, 3'd0, 32'd1000,   1'b0, 2'd0, 3'd3},
    '{8'h04, 1'b1, 1'b1, 8'd3, 3'd2, 32'd65536,  1'b1, 2'd1, 3'd0},
    '{8'h04, 1'b1, 1'b0, 8'd3, 3'd0, 32'd65537,  1'b0, 2'd0, 3'd4},
    '{8'h04, 1'b0, 1'b1, 8'd7, 3'd0, 32'd70000,  1'b0, 2'd0, 3'd2},
    '{8'h04, 1'b1, 1'b0, 8'd0, 3'd0, 32'd99999,  1'b0, 2'd0, 3'd3},
    '{8'h10, 1'b0, 1'b1, 8'd9, 3'd5, 32'd123456, 1'b1, 2'd2, 3'd0},
    '{8'h05, 1'b0, 1'b0, 8'd0, 3'd0, 32'd0,      1'b1, 2'd3, 3'd0},
    '{8'h22, 1'b1, 1'b0, 8'd3, 3'd0, 32'd10,     1'b0, 2'd0, 3'd1}
  };

  function automatic logic [63:0] mk_hdr(vec_t v);
    logic [63:0] w = '0;
    w[63:56] = v.id; w[55] = v.d1p; w[54] = v.bb;
    w[42:35] = v.d1sz; w[34:32] = v.off; w[31:0] = v.cnt;
    w[50:44] = 7'h5a; // unused bits set
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic v, input logic s, input logic e, input logic [63:0] d);
    @(negedge clk);
    in_valid = v; in_sop = s; in_eop = e; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic wr_tbl(input logic [1:0] idx, input logic en, input logic [7:0] id, input logic [1:0] q);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_en = en; tbl_id = id; tbl_q = q;
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic chk_cnts(input string req);
    chk(req, "cnt_unknown", 64'(c_unk), 64'(exp_cnt[0]));
    chk(req, "cnt_d1p", 64'(c_d1p), 64'(exp_cnt[1]));
    chk(req, "cnt_d1sz", 64'(c_d1sz), 64'(exp_cnt[2]));
    chk(req, "cnt_len", 64'(c_len), 64'(exp_cnt[3]));
  endtask

  task automatic chk_fields(input string req, input logic [63:0] h);
    chk(req, "hdr_ulp", 64'(h_ulp), 64'(h[63:56]));
    chk(req, "hdr_d1p", 64'(h_d1p), 64'(h[55]));
    chk(req, "hdr_bb", 64'(h_bb), 64'(h[54]));
    chk(req, "hdr_d1sz", 64'(h_d1sz), 64'(h[42:35]));
    chk(req, "hdr_d2off", 64'(h_d2off), 64'(h[34:32]));
    chk(req, "hdr_d2cnt", 64'(h_d2cnt), 64'(h[31:0]));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] h;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1", "out_valid in reset", 64'(out_valid), 0);
    chk("R1", "drop in reset", 64'(drop), 0);
    chk_cnts("R1");
    chk_fields("R1", 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "acc after reset", 64'(acc), 0);
    // R1 empty table: any identifier is unknown
    h = mk_hdr(VECS[0]);
    drv(1, 1, 1, h);
    chk("R1", "empty table drop", 64'(drop), 1);
    chk("R1", "empty table no out", 64'(out_valid), 0);
    exp_cnt[0]++;
    chk_cnts("R1");

    // R2 table load, duplicate 0x10 at idx 3 must lose to idx 1
    wr_tbl(2'd0, 1'b1, 8'h04, 2'd1);
    wr_tbl(2'd1, 1'b1, 8'h10, 2'd2);
    wr_tbl(2'd2, 1'b1, 8'h05, 2'd3);
    wr_tbl(2'd3, 1'b1, 8'h10, 2'd0);

    // vector walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < N_VEC; i++) begin
      vec_t v = VECS[i];
      logic [63:0] d1 = 64'h1111_0000_0000_0000 + 64'(i);
      logic [63:0] d2 = 64'hEEEE_0000_0000_0000 + 64'(i);
      h = mk_hdr(v);
      drv(1, 1, 0, h);
      chk("R3", "hdr out_valid", 64'(out_valid), 64'(v.acc));
      chk("R4", "drop pulse", 64'(drop), 64'(!v.acc));
      chk("R3", "acc pulse", 64'(acc), 64'(v.acc));
      if (v.acc) begin
        chk("R3", "hdr data", out_data, h);
        chk("R3", "sop", 64'(out_sop), 1);
        chk("R2", "qsel", 64'(out_qsel), 64'(v.q));
        last_hdr = h;
      end
      chk_fields("R9", last_hdr);
      if (i % 2 == 1) begin
        drv(0, 0, 0, 64'hDEAD);
        chk("R11", "bubble no output", 64'(out_valid), 0);
      end
      drv(1, 0, 0, d1);
      chk("R4", "mid valid", 64'(out_valid), 64'(v.acc));
      if (v.acc) chk("R3", "mid data", out_data, d1);
      drv(1, 0, 1, d2);
      chk("R4", "eop valid", 64'(out_valid), 64'(v.acc));
      if (v.acc) begin
        chk("R3", "eop data", out_data, d2);
        chk("R3", "eop flag", 64'(out_eop), 1);
        chk("R3", "qsel held", 64'(out_qsel), 64'(v.q));
      end
      chk_fields("R9", last_hdr);
      if (v.rsn != 0) exp_cnt[v.rsn - 1]++;
      chk_cnts("R8");
    end

    // R11 stray word with no open packet
    drv(1, 0, 1, 64'h0404_0000_0000_0001);
    chk("R11", "stray suppressed", 64'(out_valid), 0);
    chk("R11", "stray no drop", 64'(drop), 0);
    chk_cnts("R11");

    // R11 single-word packet
    h = mk_hdr(VECS[8]);
    drv(1, 1, 1, h);
    chk("R11", "single valid", 64'(out_valid), 1);
    chk("R11", "single sop", 64'(out_sop), 1);
    chk("R11", "single eop", 64'(out_eop), 1);
    chk("R10", "single qsel", 64'(out_qsel), 3);
    last_hdr = h;
    drv(1, 0, 0, 64'h77);
    chk("R11", "after single no out", 64'(out_valid), 0);

    // R2 disable entry 2: identifier 5 becomes unknown
    wr_tbl(2'd2, 1'b0, 8'h05, 2'd3);
    drv(1, 1, 1, h);
    chk("R2", "disabled entry drop", 64'(drop), 1);
    exp_cnt[0]++;
    chk_cnts("R2");
    chk_fields("R9", last_hdr);

    // R2 disable entry 1: duplicate at idx 3 now supplies queue 0
    wr_tbl(2'd1, 1'b0, 8'h10, 2'd2);
    h = mk_hdr(VECS[7]);
    drv(1, 1, 1, h);
    chk("R2", "dup fallback acc", 64'(acc), 1);
    chk("R2", "dup fallback qsel", 64'(out_qsel), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule